// File: doc/BRIEF.md
# SONET Frame Pattern Aligner

This block takes a recovered serial line, one bit per clock, and looks for the SONET framing word: three A1 bytes (0xF6) followed directly by three A2 bytes (0x28), 48 bits in all, each byte sent most significant bit first. When the word is seen while hunting, the bit position where it ended becomes the byte boundary. A byte strobe then marks every eighth bit on that boundary, for a downstream deserializer. A frame pulse marks each framing word that ends on the boundary.

Hunting is controlled by an out-of-frame input. A rising edge on it starts the hunt. The hunt goes on while the input stays high, so a match moves the boundary but does not end the hunt. It ends at the clock edge after a match, when the input is low at that edge. Outside the hunt the boundary is fixed, and framing words at other bit positions are ignored.

Top module: `frm_align`

## Requirements
- R1: The frame pulse is raised in the cycle after the clock edge that samples the 48th bit of the framing word 0xF6F6F6282828 (MSB first), provided that cycle carries a byte strobe.
- R2: A 48-bit word that differs from the framing word in any one bit gives no frame pulse and does not move the byte strobe.
- R3: A low-to-high change of the out-of-frame input, seen at a clock edge, makes the hunt indicator high after that edge.
- R4: While the out-of-frame input is high, the hunt stays on, even across framing word matches.
- R5: The hunt turns off at the clock edge that follows a match cycle, when the out-of-frame input is low at that edge. With no match, the hunt stays on when the input is low.
- R6: During the hunt, a match at any bit position makes the byte strobe fire in the match cycle and every 8 cycles after it.
- R7: Outside the hunt, the byte strobe phase does not change. A framing word that ends off the boundary gives no frame pulse.
- R8: The frame pulse lasts one cycle and only ever coincides with a byte strobe.
- R9: Without a new boundary, the byte strobe fires exactly once every 8 clocks.
- R10: During reset and after it, the hunt is off, the frame pulse is low, and the boundary is at offset 0. The strobe is high while reset is held and fires in cycles 8, 16, and so on after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_i | input | 1 | Serial data bit, MSB of each byte first |
| oof_i | input | 1 | Out-of-frame: a rising edge starts the hunt |
| byte_stb_o | output | 1 | High in the cycle that completes a byte on the current boundary |
| frame_o | output | 1 | Frame pulse, one cycle, on an aligned framing word |
| hunt_o | output | 1 | High while the pattern hunt is on |

## Verification
A single match can do two things in the same cycle: it sets a new boundary, and it raises the frame pulse on that boundary. The bench provokes this by sending the framing word during the hunt, ending at a bit offset different from the current strobe phase. It then expects both the strobe and the frame pulse in that very cycle, and strobes every 8 cycles after. A second case joins the end-of-hunt decision with the boundary load. The bench drops the out-of-frame input so that the match cycle still loads the boundary and the following edge clears the hunt. A cycle-accurate model scores the strobe, pulse and hunt outputs in both cases.

// File: rtl/frm_pkg.sv
package frm_pkg;
   localparam int MAX_PAT_W = 128;

   // Builds the framing word: nrep copies of lead byte, then nrep of trail byte
   function automatic logic [MAX_PAT_W-1:0] build_pattern(
      input logic [15:0] lead, input logic [15:0] trail, input int nrep, input int bw);
      logic [MAX_PAT_W-1:0] p;
      logic [MAX_PAT_W-1:0] msk;
      p   = '0;
      msk = (MAX_PAT_W'(1) << bw) - MAX_PAT_W'(1);
      for (int i = 0; i < 2*nrep; i++) begin
         p = (p << bw) | ((i < nrep) ? (MAX_PAT_W'(lead) & msk) : (MAX_PAT_W'(trail) & msk));
      end
      return p;
   endfunction
endpackage

// File: rtl/frm_match.sv
module frm_match
   import frm_pkg::*;
#(
   parameter int          BYTE_W = 8,
   parameter int          NREP   = 3,
   parameter logic [15:0] LEAD   = 16'h00F6,
   parameter logic [15:0] TRAIL  = 16'h0028
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_i,
   output logic match_o
);
   localparam int NBYTES = 2*NREP;
   localparam int PAT_W  = NBYTES*BYTE_W;
   localparam logic [MAX_PAT_W-1:0] PAT_FULL = build_pattern(LEAD, TRAIL, NREP, BYTE_W);
   localparam logic [PAT_W-1:0]     PAT      = PAT_FULL[PAT_W-1:0];

   if (PAT_W > MAX_PAT_W) begin : g_bad_w
      $error("frm_match: pattern wider than MAX_PAT_W");
   end

   logic [PAT_W-1:0]  hist_q;
   logic [NBYTES-1:0] byte_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= {hist_q[PAT_W-2:0], ser_i};
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_cmp
      assign byte_hit[g] = (hist_q[g*BYTE_W +: BYTE_W] == PAT[g*BYTE_W +: BYTE_W]);
   end

   assign match_o = &byte_hit;
endmodule

// File: rtl/frm_hunt.sv
module frm_hunt (
   input  logic clk,
   input  logic rst_n,
   input  logic oof_i,
   input  logic match_i,
   output logic hunt_o
);
   logic oof_q;
   logic hunt_q;
   logic arm;
   logic done;

   assign arm  = oof_i & ~oof_q;
   assign done = hunt_q & match_i & ~oof_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oof_q  <= 1'b0;
         hunt_q <= 1'b0;
      end else begin
         oof_q <= oof_i;
         if (arm)       hunt_q <= 1'b1;
         else if (done) hunt_q <= 1'b0;
      end
   end

   assign hunt_o = hunt_q;

   // R3
   arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oof_i && !oof_q) |=> hunt_o);
   // R4
   hold_while_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hunt_o && oof_i) |=> hunt_o);
   // R5
   end_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hunt_o) |-> $past(match_i));
endmodule

// File: rtl/frm_phase.sv
module frm_phase #(
   parameter int BYTE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic stb_o
);
   localparam int PH_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W-1);

   if (BYTE_W < 2) begin : g_bad_bw
      $error("frm_phase: BYTE_W must be at least 2");
   end

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] bnd_q;
   logic [PH_W-1:0] bnd_eff;

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bnd_q <= '0;
      else if (load_i) bnd_q <= ph_q;
   end

   assign bnd_eff = load_i ? ph_q : bnd_q;
   assign stb_o   = (ph_q == bnd_eff);

   // R9
   stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> (!stb_o || load_i));
endmodule

// File: rtl/frm_align.sv
module frm_align #(
   parameter int          BYTE_W = 8,
   parameter int          NREP   = 3,
   parameter logic [15:0] LEAD   = 16'h00F6,
   parameter logic [15:0] TRAIL  = 16'h0028
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_i,
   input  logic oof_i,
   output logic byte_stb_o,
   output logic frame_o,
   output logic hunt_o
);
   if (NREP < 1) begin : g_bad_rep
      $error("frm_align: NREP must be at least 1");
   end

   logic match;
   logic hunt;
   logic load;

   frm_match #(.BYTE_W(BYTE_W), .NREP(NREP), .LEAD(LEAD), .TRAIL(TRAIL)) u_match (
      .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .match_o(match));

   frm_hunt u_hunt (
      .clk(clk), .rst_n(rst_n), .oof_i(oof_i), .match_i(match), .hunt_o(hunt));

   assign load = hunt & match;

   frm_phase #(.BYTE_W(BYTE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .load_i(load), .stb_o(byte_stb_o));

   assign frame_o = match & byte_stb_o;
   assign hunt_o  = hunt;

   // R8
   pulse_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o |-> byte_stb_o);
   // R8
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o |=> !frame_o);
endmodule

// File: tb/test_frm_align.sv
module test_frm_align;
   localparam logic [47:0] PAT = 48'hF6F6F6282828;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_i = 1'b0;
   logic oof_i = 1'b0;
   logic byte_stb_o, frame_o, hunt_o;

   int n_vec = 0;
   int n_bad = 0;

   // reference model state
   logic [47:0] m_hist = '0;
   logic m_hunt = 1'b0, m_mprev = 1'b0, m_oprev = 1'b0;
   int m_p = 0;
   int k = 0;
   string cur_tag = "R10";

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   frm_align i_frm_align (
      .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .oof_i(oof_i),
      .byte_stb_o(byte_stb_o), .frame_o(frame_o), .hunt_o(hunt_o));

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at bit %0d: got %b expected %b", tag, what, k, act, exp);
      end
   endtask

   // driver: apply one bit, step model, push expectation (called at a negedge)
   task automatic send_bit(input logic b, input logic o);
      logic rise, m, stb;
      ser_i = b;
      oof_i = o;
      @(posedge clk);
      #1;
      k++;
      rise = o && !m_oprev;
      if (rise) m_hunt = 1'b1;
      else if (m_hunt && m_mprev && !o) m_hunt = 1'b0;
      m_oprev = o;
      m_hist = {m_hist[46:0], b};
      m = (m_hist == PAT);
      if (m_hunt && m) m_p = k % 8;
      stb = (((k - m_p) % 8 + 8) % 8) == 0;
      exp_q.push_back({stb, m && stb, m_hunt});
      tag_q.push_back(cur_tag);
      m_mprev = m;
      @(negedge clk);
   endtask

   task automatic send_pat(input int flip, input logic o);
      for (int i = 47; i >= 0; i--) send_bit(PAT[i] ^ (i == flip), o);
   endtask

   // zero-pad so the next 48-bit word ends at cycle k with k mod 8 == target
   task automatic pad_to(input int target, input logic o);
      int n;
      n = ((target - (k + 48)) % 8 + 16) % 8;
      for (int i = 0; i < n; i++) send_bit(1'b0, o);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         logic [2:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, "byte_stb", byte_stb_o, e[2]);
         chk(t, "frame", frame_o, e[1]);
         chk(t, "hunt", hunt_o, e[0]);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired at bit %0d", k);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 state held in reset
      chk("R10", "byte_stb in reset", byte_stb_o, 1'b1);
      chk("R10", "frame in reset", frame_o, 1'b0);
      chk("R10", "hunt in reset", hunt_o, 1'b0);
      rst_n = 1'b1;

      // R10 R9: idle line, strobe at offset 0 every 8
      cur_tag = "R10";
      for (int i = 0; i < 20; i++) send_bit(i[0] ^ i[2], 1'b0);

      // R7: framing word off boundary, no hunt
      cur_tag = "R7";
      pad_to(3, 1'b0);
      send_pat(-1, 1'b0);

      // R3: rising out-of-frame edge starts hunt
      cur_tag = "R3";
      for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b1);

      // R6 R1: match at offset 3 moves boundary and pulses in same cycle
      cur_tag = "R6";
      pad_to(3, 1'b1);
      send_pat(-1, 1'b1);
      cur_tag = "R4";
      for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b1);

      // R4 R6: second match at offset 5 while input high, hunt kept
      cur_tag = "R4";
      pad_to(5, 1'b1);
      send_pat(-1, 1'b1);
      for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b1);

      // R2 R5: input low, one-bit error, no pulse, hunt kept
      cur_tag = "R2";
      pad_to(6, 1'b0);
      send_pat(20, 1'b0);
      send_pat(0, 1'b0);
      for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b0);

      // R5 R1: clean match at offset 6 with input low ends hunt
      cur_tag = "R5";
      pad_to(6, 1'b0);
      send_pat(-1, 1'b0);
      for (int i = 0; i < 12; i++) send_bit(1'b0, 1'b0);

      // R7: off-boundary word after hunt, frozen phase
      cur_tag = "R7";
      pad_to(1, 1'b0);
      send_pat(-1, 1'b0);
      for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b0);

      // R8 R1: aligned word after hunt still pulses
      cur_tag = "R8";
      pad_to(6, 1'b0);
      send_pat(-1, 1'b0);
      cur_tag = "R9";
      for (int i = 0; i < 30; i++) send_bit(i[1], 1'b0);

      @(negedge clk);
      #1;
      chk("R9", "scoreboard drained", exp_q.size() == 0, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule